// File: doc/BRIEF.md
# Pointer-Addressed Banked Line Store

This block is the data side of one cache slice in which the four words of a line half no longer have to sit at one shared set and way. The storage is split into four banks. Each bank keeps, for every way and every set, two 64-bit words: one for the lower half of a line and one for the upper half. A 512-bit line therefore spreads over the four banks, with 128 bits in each bank. Every bank has its own 64-bit read bus, so the slice moves 256 bits per cycle. A whole line takes two beats: the lower 256 bits first, then the upper 256 bits.

Each request carries four location pointers, one per bank. Each pointer holds a set number and a way number. In a deduplicating cache, these pointers come from the tag entry. Each bank follows only its own pointer. This lets the words of one logical line come from different sets and different ways while all four banks still work in parallel. A word's bank and half stay fixed by its position in the line. Requests are two-beat transfers accepted over a valid/ready handshake. Reads return one half per cycle, one cycle after each beat. Writes place each of the eight payload words at its own bank's pointer.

Top module: `ptr_line_store`

## Requirements
- R1: During and right after reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: When a read is accepted at a clock edge, the response follows on the next two cycles. In the first cycle `rsp_valid` is 1 and `rsp_half` is 0. In the second cycle `rsp_valid` is 1 and `rsp_half` is 1. After that, `rsp_valid` is 0 unless another read has been accepted.
- R3: While `rsp_half` is h, `rsp_data[64b+63:64b]` equals the word stored in bank b, half h, at bank b's pointer. That word is word 4h+b of the line.
- R4: Each bank is addressed only by its own pointer field. The field for bank b is `req_ptr[6b+5:6b]`. Bits [3:0] of the field hold the set and bits [5:4] hold the way. The four banks may name four different set/way pairs in one request.
- R5: `req_ready` is 0 in exactly the one cycle that follows an acceptance and is 1 otherwise. A request presented while `req_ready` is 0 has no effect.
- R6: An accepted write stores payload word w (`req_wdata[64w+63:64w]`, w = 0..7) in bank w mod 4, half w/4, at that bank's pointer. A write produces no response.
- R7: A write changes no stored word other than the eight it addresses. Other ways, other sets and the other half of each bank keep their values.
- R8: In any cycle, at most one way's storage in each bank is enabled. This is the rule for ways that share a bank's bus.
- R9: Requests can be accepted every second cycle with no gap in the read data. A read accepted right after a write returns the newly written words.
- R10: The pointers, the command and the upper payload half are taken at acceptance. Changing them in the following cycle does not alter the second beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write line, 0 = read line |
| req_ptr | input | 24 | Four per-bank pointers, 6 bits each: {way[1:0], set[3:0]} |
| req_wdata | input | 512 | Write payload, word w at bits [64w+63:64w] |
| rsp_valid | output | 1 | Read data valid |
| rsp_half | output | 1 | 0 = lower 256 bits of the line, 1 = upper 256 bits |
| rsp_data | output | 256 | Read data, bank b at bits [64b+63:64b] |

## Verification
The storage is first filled with uniform pointers, where all four banks name the same set and way. Reads with uniform pointers then confirm the word-to-bank and half mapping. Reads with scattered pointers, where every bank names a different set and way, would pass a design that decoded only one shared pointer only if bank 0's field happened to fit every bank, so these reads separate per-bank decoding from shared decoding. Scattered writes followed by reads of neighbouring ways and sets expose writes that spill outside the addressed entries. Reads issued every second cycle, with junk requests held on the inputs during the busy beat, separate correct capture at acceptance from designs that sample the inputs again on the second beat or that accept during that beat.

// File: rtl/plstore_pkg.sv
`timescale 1ns/1ps
package plstore_pkg;

    // Which 256-bit half of a line a beat carries
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    localparam int unsigned DEF_SETS   = 16;
    localparam int unsigned DEF_WAYS   = 4;
    localparam int unsigned DEF_BANKS  = 4;
    localparam int unsigned DEF_WORD_W = 64;

    // Index width that never collapses to zero bits
    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/plstore_bank.sv
`timescale 1ns/1ps
// One bank: every way holds two words (lower/upper half) per set.
// The ways share one read bus, so only the pointed way is enabled.
module plstore_bank
    import plstore_pkg::*;
#(
    parameter int NUM_SETS = DEF_SETS,
    parameter int NUM_WAYS = DEF_WAYS,
    parameter int WORD_W   = DEF_WORD_W,
    localparam int SET_W   = idx_width(NUM_SETS),
    localparam int WAY_W   = idx_width(NUM_WAYS),
    localparam int ROW_W   = SET_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic                wr,
    input  half_e               half,
    input  logic [SET_W-1:0]    set_idx,
    input  logic [WAY_W-1:0]    way_idx,
    input  logic [WORD_W-1:0]   wdata,
    output logic [NUM_WAYS-1:0] way_en,
    output logic [WORD_W-1:0]   rdata
);

    logic [ROW_W-1:0]  row;
    logic [WORD_W-1:0] way_bus [NUM_WAYS];
    logic [WORD_W-1:0] bus;

    assign row = {set_idx, logic'(half)};

    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            way_en[w] = go && (way_idx == WAY_W'(w));
        end
    end

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [WORD_W-1:0] cells [2*NUM_SETS];

        always_ff @(posedge clk) begin
            if (way_en[w] && wr) begin
                cells[row] <= wdata;
            end
        end

        assign way_bus[w] = way_en[w] ? cells[row] : '0;
    end

    always_comb begin
        bus = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            bus = bus | way_bus[w];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (go && !wr) begin
            rdata <= bus;
        end
    end

endmodule

// File: rtl/plstore_seq.sv
`timescale 1ns/1ps
// Two-beat request sequencer: beat 0 runs on the accepting edge using
// the live inputs, beat 1 runs on the next edge from captured copies.
module plstore_seq
    import plstore_pkg::*;
#(
    parameter int NUM_BANKS = DEF_BANKS,
    parameter int PTR_W     = 6,
    parameter int WORD_W    = DEF_WORD_W,
    localparam int PTRS_W   = NUM_BANKS * PTR_W,
    localparam int HALF_W   = NUM_BANKS * WORD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [PTRS_W-1:0]   req_ptr,
    input  logic [2*HALF_W-1:0] req_wdata,
    output logic                req_ready,
    output logic                go,
    output logic                wr,
    output half_e               half,
    output logic [PTRS_W-1:0]   beat_ptr,
    output logic [HALF_W-1:0]   beat_wdata
);

    logic              busy_q;
    logic              wr_q;
    logic [PTRS_W-1:0] ptr_q;
    logic [HALF_W-1:0] whi_q;
    logic              accept;

    assign req_ready = !busy_q;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            wr_q   <= 1'b0;
            ptr_q  <= '0;
            whi_q  <= '0;
        end else begin
            busy_q <= accept;
            if (accept) begin
                wr_q  <= req_write;
                ptr_q <= req_ptr;
                whi_q <= req_wdata[2*HALF_W-1:HALF_W];
            end
        end
    end

    assign go         = accept || busy_q;
    assign wr         = busy_q ? wr_q : req_write;
    assign half       = busy_q ? HALF_HI : HALF_LO;
    assign beat_ptr   = busy_q ? ptr_q : req_ptr;
    assign beat_wdata = busy_q ? whi_q : req_wdata[HALF_W-1:0];

endmodule

// File: rtl/ptr_line_store.sv
`timescale 1ns/1ps
module ptr_line_store
    import plstore_pkg::*;
#(
    parameter int NUM_SETS  = DEF_SETS,
    parameter int NUM_WAYS  = DEF_WAYS,
    parameter int NUM_BANKS = DEF_BANKS,
    parameter int WORD_W    = DEF_WORD_W,
    localparam int SET_W    = idx_width(NUM_SETS),
    localparam int WAY_W    = idx_width(NUM_WAYS),
    localparam int PTR_W    = SET_W + WAY_W,
    localparam int PTRS_W   = NUM_BANKS * PTR_W,
    localparam int HALF_W   = NUM_BANKS * WORD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [PTRS_W-1:0]   req_ptr,
    input  logic [2*HALF_W-1:0] req_wdata,
    output logic                rsp_valid,
    output logic                rsp_half,
    output logic [HALF_W-1:0]   rsp_data
);

    logic                          go;
    logic                          wr;
    half_e                         half;
    logic [PTRS_W-1:0]             beat_ptr;
    logic [HALF_W-1:0]             beat_wdata;
    logic [NUM_BANKS*NUM_WAYS-1:0] way_en_all;
    logic                          rsp_valid_q;
    half_e                         rsp_half_q;

    plstore_seq #(
        .NUM_BANKS (NUM_BANKS),
        .PTR_W     (PTR_W),
        .WORD_W    (WORD_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_ptr    (req_ptr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .go         (go),
        .wr         (wr),
        .half       (half),
        .beat_ptr   (beat_ptr),
        .beat_wdata (beat_wdata)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [PTR_W-1:0] ptr_b;
        assign ptr_b = beat_ptr[b*PTR_W +: PTR_W];

        plstore_bank #(
            .NUM_SETS (NUM_SETS),
            .NUM_WAYS (NUM_WAYS),
            .WORD_W   (WORD_W)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .go      (go),
            .wr      (wr),
            .half    (half),
            .set_idx (ptr_b[SET_W-1:0]),
            .way_idx (ptr_b[PTR_W-1:SET_W]),
            .wdata   (beat_wdata[b*WORD_W +: WORD_W]),
            .way_en  (way_en_all[b*NUM_WAYS +: NUM_WAYS]),
            .rdata   (rsp_data[b*WORD_W +: WORD_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_half_q  <= HALF_LO;
        end else begin
            rsp_valid_q <= go && !wr;
            rsp_half_q  <= half;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_half  = logic'(rsp_half_q);

endmodule

// File: rtl/plstore_checker.sv
`timescale 1ns/1ps
module plstore_checker #(
    parameter int NUM_BANKS = 4,
    parameter int NUM_WAYS  = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          req_valid,
    input logic                          req_ready,
    input logic                          req_write,
    input logic                          rsp_valid,
    input logic                          rsp_half,
    input logic [NUM_BANKS*NUM_WAYS-1:0] way_en_all
);

    assert_ready_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_ready_back_R5: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> req_ready);

    assert_first_half_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write) |=> (rsp_valid && !rsp_half));

    assert_second_half_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_half) |=> (rsp_valid && rsp_half));

    assert_no_third_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_half) |=> (!rsp_valid || !rsp_half));

    assert_write_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |=> !rsp_valid);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bus
        assert_one_way_R8: assert property (@(posedge clk) disable iff (rst)
            $onehot0(way_en_all[b*NUM_WAYS +: NUM_WAYS]));
    end

endmodule

bind ptr_line_store plstore_checker #(
    .NUM_BANKS (NUM_BANKS),
    .NUM_WAYS  (NUM_WAYS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .rsp_valid  (rsp_valid),
    .rsp_half   (rsp_half),
    .way_en_all (way_en_all)
);

// File: tb/sim_ptr_line_store.sv
`timescale 1ns/1ps
module sim_ptr_line_store;

    localparam int SETS = 16;
    localparam int WAYS = 4;
    localparam int BANKS = 4;

    typedef struct {
        bit           v;
        bit           h;
        logic [255:0] d;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic         req_ready;
    logic         req_write;
    logic [23:0]  req_ptr;
    logic [511:0] req_wdata;
    logic         rsp_valid;
    logic         rsp_half;
    logic [255:0] rsp_data;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    bit    exp_ready = 1;
    string tag = "R1";
    exp_t  q[$];
    logic [63:0] ref_mem [BANKS][WAYS][SETS][2];

    always #4 clk = ~clk;

    ptr_line_store u0 (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_ptr   (req_ptr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_half  (rsp_half),
        .rsp_data  (rsp_data)
    );

    task automatic chk(input bit ok, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Pointer field for bank b: {way[1:0], set[3:0]}
    function automatic logic [23:0] mkptr(input int s0, input int sstep,
                                          input int w0, input int wstep);
        logic [23:0] p;
        for (int b = 0; b < BANKS; b++) begin
            p[6*b +: 4]     = 4'((s0 + b*sstep) % SETS);
            p[6*b + 4 +: 2] = 2'((w0 + b*wstep) % WAYS);
        end
        return p;
    endfunction

    function automatic logic [511:0] mkline(input int a, input int c, input int seed);
        logic [511:0] l;
        for (int w = 0; w < 8; w++) begin
            l[64*w +: 64] = {16'(w), 16'(a), 16'(c), 16'(seed)};
        end
        return l;
    endfunction

    task automatic compare_now();
        exp_t e;
        if (q.size() > 0) e = q.pop_front();
        else e = '{v: 1'b0, h: 1'b0, d: '0};
        chk(req_ready === exp_ready, "req_ready", 256'(req_ready), 256'(exp_ready));
        chk(rsp_valid === e.v, "rsp_valid", 256'(rsp_valid), 256'(e.v));
        if (e.v) begin
            chk(rsp_half === e.h, "rsp_half", 256'(rsp_half), 256'(e.h));
            chk(rsp_data === e.d, "rsp_data", rsp_data, e.d);
        end
    endtask

    task automatic cycle(input bit v, input bit wr, input logic [23:0] p,
                         input logic [511:0] d);
        exp_t e;
        @(negedge clk);
        compare_now();
        req_valid = v;
        req_write = wr;
        req_ptr   = p;
        req_wdata = d;
        if (v && exp_ready) begin
            if (wr) begin
                for (int w = 0; w < 8; w++) begin
                    ref_mem[w % 4][p[6*(w%4)+4 +: 2]][p[6*(w%4) +: 4]][w/4] = d[64*w +: 64];
                end
                q.push_back('{v: 1'b0, h: 1'b0, d: '0});
                q.push_back('{v: 1'b0, h: 1'b0, d: '0});
            end else begin
                for (int h = 0; h < 2; h++) begin
                    e.v = 1'b1;
                    e.h = h[0];
                    for (int b = 0; b < BANKS; b++) begin
                        e.d[64*b +: 64] = ref_mem[b][p[6*b+4 +: 2]][p[6*b +: 4]][h];
                    end
                    q.push_back(e);
                end
            end
            exp_ready = 0;
        end else begin
            exp_ready = 1;
        end
    endtask

    task automatic idle();
        cycle(0, 0, '0, '0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_ptr = '0;
        req_wdata = '0;
        repeat (3) @(negedge clk);
        tag = "R1";
        chk(req_ready === 1'b1, "ready in reset", 256'(req_ready), 256'(1));
        chk(rsp_valid === 1'b0, "valid in reset", 256'(rsp_valid), 256'(0));
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1, "ready after reset", 256'(req_ready), 256'(1));
        chk(rsp_valid === 1'b0, "valid after reset", 256'(rsp_valid), 256'(0));

        // Fill every set and way with uniform pointers
        tag = "R6";
        for (int w = 0; w < WAYS; w++) begin
            for (int s = 0; s < SETS; s++) begin
                cycle(1, 1, mkptr(s, 0, w, 0), mkline(w, s, 1));
                idle();
            end
        end

        tag = "R3";
        for (int i = 0; i < 8; i++) begin
            cycle(1, 0, mkptr(i*2, 0, i % 4, 0), '0);
            idle();
        end

        tag = "R4 R8";
        for (int i = 0; i < 12; i++) begin
            cycle(1, 0, mkptr(i, 3, i, 1), '0);
            idle();
        end

        // Junk held during the busy beat must not be taken or leak in
        tag = "R10 R5";
        cycle(1, 0, mkptr(5, 1, 2, 1), '0);
        cycle(1, 1, mkptr(0, 0, 0, 0), {16{32'hDEAD_BEEF}});
        cycle(1, 0, mkptr(0, 0, 0, 0), '0);
        idle();
        cycle(1, 1, mkptr(9, 2, 3, 1), mkline(7, 7, 55));
        cycle(1, 1, mkptr(1, 1, 1, 1), {16{32'h0BAD_F00D}});
        cycle(1, 0, mkptr(9, 2, 3, 1), '0);
        cycle(1, 0, mkptr(1, 1, 1, 1), '0);
        idle();

        tag = "R7";
        cycle(1, 1, mkptr(7, 5, 1, 3), mkline(3, 9, 99));
        idle();
        cycle(1, 0, mkptr(7, 5, 1, 3), '0);
        idle();
        cycle(1, 0, mkptr(7, 5, 2, 3), '0);
        idle();
        cycle(1, 0, mkptr(8, 5, 1, 3), '0);
        idle();
        cycle(1, 0, mkptr(6, 5, 0, 3), '0);
        idle();

        tag = "R9";
        for (int i = 0; i < 10; i++) begin
            cycle(1, 0, mkptr(i, 7, i, 3), '0);
            cycle(1, 0, mkptr(i + 1, 7, i + 1, 3), '0);
        end
        cycle(1, 1, mkptr(2, 9, 0, 1), mkline(5, 5, 123));
        cycle(1, 0, mkptr(2, 9, 0, 1), '0);
        cycle(1, 0, mkptr(2, 9, 0, 1), '0);
        cycle(1, 0, mkptr(3, 9, 0, 1), '0);

        tag = "R2";
        repeat (4) idle();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule